// File: doc/BRIEF.md
# Dual-Supply Power-Path Selection Controller

This block decides which of two supply switches feeds a shared output rail, or whether neither does. The analog parts around it (comparators, gate drivers, current limit, charge pump) appear only as digital flags. A two-bit mode input picks supply 1, supply 2, no supply, or an automatic mode that follows whichever supply is higher. Every decision is gated by the undervoltage flags and an over-temperature flag. Switching between supplies is break-before-make, and each move waits on gate-off feedback from the other switch.

Noisy flags are deglitched by saturating counters whose lengths are parameters in clock cycles. The supply comparison is filtered on both edges. Each undervoltage flag is filtered only when it drops. The open-drain status output is delayed only when it starts pulling low. A slew-rate select tells the gate driver to ramp slowly when the rail comes up from the disconnected state, and to ramp fast when it hands over directly from one supply to the other.

Top module: `pwr_path_ctrl`

## Requirements
- R1: `modeSel` encoding: 2'b00 connects supply 2, 2'b10 connects supply 1, and 2'b11 disconnects the output (both enables low).
- R2: `modeSel` 2'b01 is automatic: supply 2 is connected when the filtered `sup2AboveSup1` is 1, otherwise supply 1.
- R3: The filtered supply comparison takes a new value only after the raw flag has differed from it for CMP_DG consecutive clock samples, on rising and falling edges alike.
- R4: A switch is enabled only while its own filtered undervoltage flag and the filtered internal-rail flag are both 1. Otherwise the output is disconnected, and the other supply is not used as a substitute.
- R5: An undervoltage flag (`sup1AboveUv`, `sup2AboveUv`, `railAboveUv`) falling takes effect only after UV_DG consecutive low samples. Rising takes effect on the next clock.
- R6: The two enables are never high in the same cycle. A switch turns on only when the other enable was already low in the previous cycle and the other switch's gate-off input was 1.
- R7: While a switch is off, it is not enabled while the matching `outOverSupN` flag is 1. Once it is on, that flag no longer affects it.
- R8: `statPullLow` is 0 (released) only while the supply 2 switch is on. The release happens one clock after `sw2En` rises. Pulling low starts after the request has held for STAT_DG consecutive samples.
- R9: `slewSlow` is set to 1 when a switch turns on after the output was disconnected, and to 0 when it turns on as a direct handover from the other supply. It holds its value between turn-ons.
- R10: When `overTemp` is 1, both enables are low in the next cycle. Normal selection resumes on the clock after it returns to 0.
- R11: During reset both enables are 0, `statPullLow` is 1 and `slewSlow` is 1. All filtered flags clear, so a switch first turns on on the second clock after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Source mode: 00 supply 2, 01 auto, 10 supply 1, 11 off |
| sup2AboveSup1 | input | 1 | Comparator: supply 2 higher than supply 1 |
| sup1AboveUv | input | 1 | Supply 1 above its undervoltage threshold |
| sup2AboveUv | input | 1 | Supply 2 above its undervoltage threshold |
| railAboveUv | input | 1 | Higher supply above the internal-rail threshold |
| outOverSup1 | input | 1 | Output exceeds supply 1 by more than the blocking margin |
| outOverSup2 | input | 1 | Output exceeds supply 2 by more than the blocking margin |
| overTemp | input | 1 | Over-temperature flag (hysteresis applied upstream) |
| sw1GateOff | input | 1 | Supply 1 switch gate is below turn-on |
| sw2GateOff | input | 1 | Supply 2 switch gate is below turn-on |
| sw1En | output | 1 | Enable for the supply 1 switch |
| sw2En | output | 1 | Enable for the supply 2 switch |
| slewSlow | output | 1 | 1 selects the slow output ramp, 0 the fast one |
| statPullLow | output | 1 | 1 pulls the open-drain status pin low, 0 releases it |

## Verification
The embedded properties check the cycle-level safety rules on every clock. They cover the enables never overlapping and each turn-on being preceded by gate-off feedback, a low opposite enable, no output-over-supply block and healthy undervoltage flags. They also cover over-temperature forcing both enables off, the status releasing on the clock after a release request, and every filter output only ever taking a value its raw input just had. The exact deglitch lengths, the rejection of glitches one sample too short, the truth-table mapping in steady state, the choice of slew rate and the resumption after faults depend on histories of many cycles. Only the bench scenarios show these, by stepping exact edge counts and sampling the ports.

// File: rtl/pwr_path_pkg.sv
`timescale 1ns/1ps
package pwr_path_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_TWO  = 2'd2
  } src_e;

  // Mode encoding: the control decodes these exact values.
  localparam logic [1:0] MODE_SUP2 = 2'b00;
  localparam logic [1:0] MODE_AUTO = 2'b01;
  localparam logic [1:0] MODE_SUP1 = 2'b10;
  localparam logic [1:0] MODE_OFF  = 2'b11;

  // Filtered comparator view handed from datapath to control.
  typedef struct packed {
    logic sup2Higher;
    logic sup1Ok;
    logic sup2Ok;
    logic railOk;
  } flags_t;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic statReq;
  } strobes_t;

endpackage

// File: rtl/ppc_deglitch.sv
`timescale 1ns/1ps
module ppc_deglitch #(
  parameter int unsigned DG        = 4,
  parameter bit          FILT_RISE = 1'b1,
  parameter bit          FILT_FALL = 1'b1,
  parameter bit          INIT      = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic raw,
  output logic q
);
  localparam int unsigned CNT_W = (DG < 2) ? 1 : $clog2(DG + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DG - 1);

  logic [CNT_W-1:0] cnt;
  logic             filtEdge;

  // Whether the pending change in direction raw is a filtered one.
  assign filtEdge = raw ? FILT_RISE : FILT_FALL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q   <= INIT;
      cnt <= '0;
    end else if (raw == q) begin
      cnt <= '0;
    end else if (!filtEdge || cnt == CNT_LAST) begin
      q   <= raw;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3 R5 R8: the filtered output only ever moves to the last raw sample.
  assert_follow_raw_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(q) |-> ($past(raw) == q));

endmodule

// File: rtl/ppc_datapath.sv
`timescale 1ns/1ps
module ppc_datapath
  import pwr_path_pkg::*;
#(
  parameter int unsigned CMP_DG  = 4,
  parameter int unsigned UV_DG   = 3,
  parameter int unsigned STAT_DG = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sup2AboveSup1,
  input  logic     sup1AboveUv,
  input  logic     sup2AboveUv,
  input  logic     railAboveUv,
  input  strobes_t strobes,
  output flags_t   flags,
  output logic     statPullLow
);
  localparam int unsigned NUM_UV = 3;

  logic [NUM_UV-1:0] uvRaw;
  logic [NUM_UV-1:0] uvFilt;

  assign uvRaw = {sup1AboveUv, sup2AboveUv, railAboveUv};

  // Supply comparison: both edges filtered.
  ppc_deglitch #(.DG(CMP_DG), .FILT_RISE(1'b1), .FILT_FALL(1'b1), .INIT(1'b0)) uCmp (
    .clk(clk), .rstN(rstN), .raw(sup2AboveSup1), .q(flags.sup2Higher));

  // Undervoltage flags: only the drop is filtered.
  for (genvar i = 0; i < NUM_UV; i++) begin : gUv
    ppc_deglitch #(.DG(UV_DG), .FILT_RISE(1'b0), .FILT_FALL(1'b1), .INIT(1'b0)) uUv (
      .clk(clk), .rstN(rstN), .raw(uvRaw[i]), .q(uvFilt[i]));
  end

  assign flags.sup1Ok = uvFilt[2];
  assign flags.sup2Ok = uvFilt[1];
  assign flags.railOk = uvFilt[0];

  // Status: pulling low is delayed, release is immediate.
  ppc_deglitch #(.DG(STAT_DG), .FILT_RISE(1'b1), .FILT_FALL(1'b0), .INIT(1'b1)) uStat (
    .clk(clk), .rstN(rstN), .raw(strobes.statReq), .q(statPullLow));

  assert_stat_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.statReq |=> !statPullLow);

endmodule

// File: rtl/ppc_control.sv
`timescale 1ns/1ps
module ppc_control
  import pwr_path_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  flags_t     flags,
  input  logic       outOverSup1,
  input  logic       outOverSup2,
  input  logic       overTemp,
  input  logic       sw1GateOff,
  input  logic       sw2GateOff,
  output logic       sw1En,
  output logic       sw2En,
  output logic       slewSlow,
  output strobes_t   strobes
);
  src_e pick;
  src_e want;
  logic en1Q, en2Q, liveQ, slowQ;
  logic en1D, en2D, liveD, slowD;

  // Source requested by the mode pins.
  always_comb begin
    case (modeSel)
      MODE_OFF:  pick = SRC_NONE;
      MODE_SUP1: pick = SRC_ONE;
      MODE_SUP2: pick = SRC_TWO;
      default:   pick = flags.sup2Higher ? SRC_TWO : SRC_ONE;
    endcase
  end

  // Qualify the request with protection flags.
  always_comb begin
    want = pick;
    if (overTemp || !flags.railOk)                 want = SRC_NONE;
    else if (pick == SRC_ONE && !flags.sup1Ok)     want = SRC_NONE;
    else if (pick == SRC_TWO && !flags.sup2Ok)     want = SRC_NONE;
  end

  // Break-before-make sequencing.
  always_comb begin
    en1D  = en1Q;
    en2D  = en2Q;
    liveD = liveQ;
    slowD = slowQ;
    case (want)
      SRC_ONE: begin
        en2D = 1'b0;
        if (!en1Q && !en2Q && sw2GateOff && !outOverSup1) begin
          en1D  = 1'b1;
          slowD = !liveQ;
          liveD = 1'b1;
        end
      end
      SRC_TWO: begin
        en1D = 1'b0;
        if (!en2Q && !en1Q && sw1GateOff && !outOverSup2) begin
          en2D  = 1'b1;
          slowD = !liveQ;
          liveD = 1'b1;
        end
      end
      default: begin
        en1D  = 1'b0;
        en2D  = 1'b0;
        liveD = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en1Q  <= 1'b0;
      en2Q  <= 1'b0;
      liveQ <= 1'b0;
      slowQ <= 1'b1;
    end else begin
      en1Q  <= en1D;
      en2Q  <= en2D;
      liveQ <= liveD;
      slowQ <= slowD;
    end
  end

  assign sw1En           = en1Q;
  assign sw2En           = en2Q;
  assign slewSlow        = slowQ;
  assign strobes.statReq = !en2Q;

  assert_never_both_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(sw1En && sw2En));
  assert_make1_after_break_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sw1En) |-> ($past(sw2GateOff) && !$past(sw2En)));
  assert_make2_after_break_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sw2En) |-> ($past(sw1GateOff) && !$past(sw1En)));
  assert_block1_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sw1En) |-> !$past(outOverSup1));
  assert_block2_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sw2En) |-> !$past(outOverSup2));
  assert_uv_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sw1En) |-> $past(flags.sup1Ok && flags.railOk));
  assert_hot_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |=> (!sw1En && !sw2En));

endmodule

// File: rtl/pwr_path_ctrl.sv
`timescale 1ns/1ps
module pwr_path_ctrl
  import pwr_path_pkg::*;
#(
  parameter int unsigned CMP_DG  = 30000,
  parameter int unsigned UV_DG   = 22000,
  parameter int unsigned STAT_DG = 30000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       sup2AboveSup1,
  input  logic       sup1AboveUv,
  input  logic       sup2AboveUv,
  input  logic       railAboveUv,
  input  logic       outOverSup1,
  input  logic       outOverSup2,
  input  logic       overTemp,
  input  logic       sw1GateOff,
  input  logic       sw2GateOff,
  output logic       sw1En,
  output logic       sw2En,
  output logic       slewSlow,
  output logic       statPullLow
);
  flags_t   flags;
  strobes_t strobes;

  ppc_datapath #(.CMP_DG(CMP_DG), .UV_DG(UV_DG), .STAT_DG(STAT_DG)) uDp (
    .clk(clk), .rstN(rstN),
    .sup2AboveSup1(sup2AboveSup1), .sup1AboveUv(sup1AboveUv),
    .sup2AboveUv(sup2AboveUv), .railAboveUv(railAboveUv),
    .strobes(strobes), .flags(flags), .statPullLow(statPullLow));

  ppc_control uCtl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .flags(flags),
    .outOverSup1(outOverSup1), .outOverSup2(outOverSup2), .overTemp(overTemp),
    .sw1GateOff(sw1GateOff), .sw2GateOff(sw2GateOff),
    .sw1En(sw1En), .sw2En(sw2En), .slewSlow(slewSlow), .strobes(strobes));

endmodule

// File: tb/sim_pwr_path_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_path_ctrl;
  localparam int CMP = 4;
  localparam int UV  = 3;
  localparam int SD  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b10;
  logic sup2AboveSup1 = 1'b0, sup1AboveUv = 1'b1, sup2AboveUv = 1'b1, railAboveUv = 1'b1;
  logic outOverSup1 = 1'b0, outOverSup2 = 1'b0, overTemp = 1'b0;
  logic sw1GateOff = 1'b1, sw2GateOff = 1'b1;
  logic sw1En, sw2En, slewSlow, statPullLow;

  int checks = 0;
  int fails  = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_path_ctrl #(.CMP_DG(CMP), .UV_DG(UV), .STAT_DG(SD)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sup2AboveSup1(sup2AboveSup1),
    .sup1AboveUv(sup1AboveUv), .sup2AboveUv(sup2AboveUv), .railAboveUv(railAboveUv),
    .outOverSup1(outOverSup1), .outOverSup2(outOverSup2), .overTemp(overTemp),
    .sw1GateOff(sw1GateOff), .sw2GateOff(sw2GateOff),
    .sw1En(sw1En), .sw2En(sw2En), .slewSlow(slewSlow), .statPullLow(statPullLow));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R6 monitor: both enables high in one cycle is never allowed.
  always @(negedge clk) if (rstN && sw1En && sw2En) overlap++;

  initial begin
    #(5ns * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    step(3);
    chk("R11", "sw1En in reset", sw1En, 0);
    chk("R11", "sw2En in reset", sw2En, 0);
    chk("R11", "statPullLow in reset", statPullLow, 1);
    chk("R11", "slewSlow in reset", slewSlow, 1);
    rstN = 1'b1;
    step(1);
    chk("R11", "sw1En one clock after reset", sw1En, 0);
    step(1);
    chk("R11", "sw1En two clocks after reset", sw1En, 1);
    chk("R9", "slow ramp from disconnected", slewSlow, 1);

    // R1 R2 R8 truth-table sweep
    for (int m = 0; m < 4; m++) begin
      for (int h = 0; h < 2; h++) begin
        int sel;
        modeSel = 2'(m);
        sup2AboveSup1 = 1'(h);
        step(20);
        sel = (m == 3) ? 0 : (m == 2) ? 1 : (m == 0) ? 2 : (h == 1 ? 2 : 1);
        chk((m == 1) ? "R2" : "R1", $sformatf("sw1En mode%0d h%0d", m, h), sw1En, int'(sel == 1));
        chk((m == 1) ? "R2" : "R1", $sformatf("sw2En mode%0d h%0d", m, h), sw2En, int'(sel == 2));
        chk("R8", $sformatf("statPullLow mode%0d h%0d", m, h), statPullLow, int'(sel != 2));
      end
    end

    // R8 release and pull-low timing (start disconnected)
    modeSel = 2'b00;
    step(1);
    chk("R8", "sw2En on", sw2En, 1);
    chk("R9", "slow from off", slewSlow, 1);
    chk("R8", "still low one clock", statPullLow, 1);
    step(1);
    chk("R8", "released next clock", statPullLow, 0);
    modeSel = 2'b11;
    step(SD);
    chk("R8", "pull-low not before STAT_DG", statPullLow, 0);
    step(1);
    chk("R8", "pull-low at STAT_DG", statPullLow, 1);
    modeSel = 2'b00;
    step(5);

    // R7 output-over block, then ignored once on
    outOverSup1 = 1'b1;
    modeSel = 2'b10;
    step(10);
    chk("R7", "sw1En blocked", sw1En, 0);
    chk("R7", "sw2En broken", sw2En, 0);
    outOverSup1 = 1'b0;
    step(1);
    chk("R7", "sw1En after block clears", sw1En, 1);
    chk("R9", "fast on handover", slewSlow, 0);
    outOverSup1 = 1'b1;
    step(5);
    chk("R7", "sw1En held despite output over", sw1En, 1);
    outOverSup1 = 1'b0;

    // R6 break-before-make waits for gate-off
    sw1GateOff = 1'b0;
    modeSel = 2'b00;
    step(10);
    chk("R6", "sw1En off", sw1En, 0);
    chk("R6", "sw2En waits for gate-off", sw2En, 0);
    sw1GateOff = 1'b1;
    step(1);
    chk("R6", "sw2En after gate-off", sw2En, 1);
    modeSel = 2'b10;
    step(5);

    // R5 undervoltage falling deglitch
    sup1AboveUv = 1'b0;
    step(UV - 1);
    sup1AboveUv = 1'b1;
    step(3);
    chk("R5", "short dip rejected", sw1En, 1);
    sup1AboveUv = 1'b0;
    step(UV);
    chk("R5", "sw1En before UV_DG", sw1En, 1);
    step(1);
    chk("R5", "sw1En off after UV_DG", sw1En, 0);
    sup1AboveUv = 1'b1;
    step(1);
    chk("R5", "rise not yet at enable", sw1En, 0);
    step(1);
    chk("R5", "rise immediate", sw1En, 1);
    chk("R9", "slow after disconnect", slewSlow, 1);

    // R4 rail and own-supply gating
    railAboveUv = 1'b0;
    step(UV + 2);
    chk("R4", "rail low disconnects", sw1En, 0);
    railAboveUv = 1'b1;
    step(2);
    chk("R4", "rail ok reconnects", sw1En, 1);
    sup2AboveUv = 1'b0;
    step(UV + 2);
    modeSel = 2'b00;
    step(5);
    chk("R4", "no substitute sw1En", sw1En, 0);
    chk("R4", "sw2En needs own supply", sw2En, 0);
    sup2AboveUv = 1'b1;
    step(3);
    chk("R4", "sw2En once supply ok", sw2En, 1);

    // R3 comparator deglitch in auto mode
    sup2AboveSup1 = 1'b0;
    modeSel = 2'b01;
    step(CMP + 5);
    chk("R3", "auto settles to supply 1", sw1En, 1);
    sup2AboveSup1 = 1'b1;
    step(CMP - 1);
    sup2AboveSup1 = 1'b0;
    step(3);
    chk("R3", "glitch rejected sw1En", sw1En, 1);
    chk("R3", "glitch rejected sw2En", sw2En, 0);
    sup2AboveSup1 = 1'b1;
    step(CMP);
    chk("R3", "rise held CMP_DG", sw1En, 1);
    step(1);
    chk("R3", "break after rise", sw1En, 0);
    chk("R3", "no make yet", sw2En, 0);
    step(1);
    chk("R3", "make supply 2", sw2En, 1);
    chk("R9", "fast handover auto", slewSlow, 0);
    sup2AboveSup1 = 1'b0;
    step(CMP);
    chk("R3", "fall held CMP_DG", sw2En, 1);
    step(1);
    chk("R3", "break after fall", sw2En, 0);
    step(1);
    chk("R3", "make supply 1", sw1En, 1);

    // R10 over-temperature
    overTemp = 1'b1;
    step(1);
    chk("R10", "sw1En forced off", sw1En, 0);
    chk("R10", "sw2En forced off", sw2En, 0);
    step(5);
    chk("R10", "stays off while hot", sw1En, 0);
    overTemp = 1'b0;
    step(1);
    chk("R10", "resumes", sw1En, 1);
    chk("R9", "slow after hot stop", slewSlow, 1);

    chk("R6", "cycles with both enables high", overlap, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule